// File: doc/BRIEF.md
# Sectored Data-Cache Tag and Coherency Directory

This block holds the tags and per-line coherency states for a direct-mapped data cache organised in sectors. A sector spans 64 bytes and is made of two 32-byte lines. The two lines share one tag, but each line keeps its own four-state coherency value (Invalid, Shared, Exclusive, Modified). Because of this, a sector can be present while the addressed line is Invalid. Such an access is reported as a sector hit with a line miss.

The processor side issues three operations on one request port: read lookups, write lookups and line fills. The system side issues snoop inquiries, which can invalidate a line or demote it to Shared. Each lookup and snoop is accepted in one cycle and answered one cycle later.

A fill to an absent sector runs a short sequence before the new line is installed. The sequence first walks the old sector and reports each Modified line for writeback. It then installs the new tag with both lines Invalid and sets the requested line to Exclusive or Shared. Data bytes, the bus interface and the writeback data path lie outside this block.

The controller has four states:
- `S_IDLE` accepts requests. A fill to an absent sector moves it to `S_WB0`.
- `S_WB0` reports the old line 0 and always moves to `S_WB1`.
- `S_WB1` reports the old line 1 and always moves to `S_ALLOC`.
- `S_ALLOC` writes the new tag and states and always returns to `S_IDLE`.

Top module: `sect_dir`

## Requirements
- R1: After reset every line is Invalid. Any lookup misses, every response output is 0, and both ready outputs are 1.
- R2: Address fields are as follows.
  - Bit 5 selects the line within a sector (0 = line 0, 1 = line 1).
  - Bits 11:6 select one of 64 sectors.
  - Bits 31:12 form the tag, which is shared by both lines.
  - Bits 4:0 are ignored.
- R3: A lookup response appears the cycle after acceptance.
  - `rsp_sect_hit_o` is 1 when the stored tag equals the address tag and at least one line of that sector is valid.
  - `rsp_line_hit_o` is 1 only when, in addition, the addressed line is not Invalid.
  - `rsp_state_o` gives the line's state before any update on a line hit, and 0 otherwise.
  - The state encoding is Invalid = 0, Shared = 1, Exclusive = 2, Modified = 3.
- R4: A write hit on an Exclusive line moves it to Modified. A write hit on a Modified line leaves it Modified. A read hit changes no state.
- R5: A write hit on a Shared line pulses `bus_wr_req_o` in the response cycle and leaves the line Shared.
- R6: A fill to a present sector writes only the addressed line: Shared if `fill_shared_i` = 1, else Exclusive. The sibling line keeps its state, and `fill_done_o` pulses the next cycle.
- R7: A fill to an absent sector works as follows.
  - It spends one cycle in each of `S_WB0`, `S_WB1` and `S_ALLOC`.
  - In `S_WB0` and `S_WB1`, `wb_valid_o` is 1 exactly when the old line 0 or line 1 (respectively) is Modified. `wb_addr_o` then gives that line's 32-byte-aligned address under the old tag.
  - The new tag is then written with both lines Invalid, except the addressed line, which is set as in R6.
  - `fill_done_o` pulses the cycle after `S_ALLOC`.
- R8: A snoop response appears the cycle after acceptance.
  - `snp_done_o` pulses, and `snp_hit_o` reports a line hit.
  - `snp_hitm_o` pulses when the hit line is Modified.
  - A hit line goes to Invalid when `snp_inv_i` = 1, else to Shared.
  - A snoop miss changes nothing.
- R9: A snoop request wins over a processor request in the same cycle. `cpu_ready_o` is 0 while `snp_req_i` is 1, and the processor request is served once it is accepted later. Neither side is accepted outside `S_IDLE`.
- R10: A write or read that misses changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req_i | input | 1 | Processor request valid |
| cpu_op_i | input | 2 | 0 read, 1 write, 2 fill |
| cpu_addr_i | input | 32 | Processor byte address |
| fill_shared_i | input | 1 | Fill installs the line Shared instead of Exclusive |
| cpu_ready_o | output | 1 | Processor request accepted this cycle when high |
| snp_req_i | input | 1 | Snoop inquiry valid |
| snp_addr_i | input | 32 | Snoop byte address |
| snp_inv_i | input | 1 | Snoop invalidates instead of demoting to Shared |
| snp_ready_o | output | 1 | Snoop accepted this cycle when high |
| rsp_valid_o | output | 1 | Lookup response valid |
| rsp_sect_hit_o | output | 1 | Sector present with matching tag |
| rsp_line_hit_o | output | 1 | Addressed line valid |
| rsp_state_o | output | 2 | Line state before update on a hit |
| bus_wr_req_o | output | 1 | Write hit on Shared needs a bus write |
| fill_done_o | output | 1 | Fill installed |
| snp_done_o | output | 1 | Snoop response valid |
| snp_hit_o | output | 1 | Snoop hit a valid line |
| snp_hitm_o | output | 1 | Snoop hit a Modified line |
| wb_valid_o | output | 1 | Evicted Modified line reported |
| wb_addr_o | output | 32 | Address of the line to write back |

## Verification
The assertions assume that a processor request is held until `cpu_ready_o` is seen high, and likewise for snoops. They also assume that the opcode value 3 is never driven. The bench keeps to this by issuing one request at a time and waiting for each response or fill to finish before the next request. The one exception is a deliberate same-cycle snoop and processor collision, which the bench holds until the processor request is granted. Random addresses are drawn from three tags and three sector indices, so sector hits, line misses and evictions of Modified lines all occur often.

// File: rtl/sect_dir_pkg.sv
package sect_dir_pkg;
    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } line_st_e;

    typedef enum logic [1:0] {
        OP_RD   = 2'd0,
        OP_WR   = 2'd1,
        OP_FILL = 2'd2
    } cpu_op_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_WB0   = 2'd1,
        S_WB1   = 2'd2,
        S_ALLOC = 2'd3
    } ctrl_st_e;
endpackage

// File: rtl/sect_dir_store.sv
module sect_dir_store
    import sect_dir_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int TAG_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output line_st_e         rd_st [2],
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_tag_en,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [1:0]       wr_line_en,
    input  line_st_e         wr_st [2]
);
    localparam int DEPTH = 1 << IDX_W;

    logic [TAG_W-1:0] tag_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) tag_q[i] <= '0;
        end else if (wr_tag_en) begin
            tag_q[wr_idx] <= wr_tag;
        end
    end

    assign rd_tag = tag_q[rd_idx];

    // Two independent state arrays, one per line of a sector.
    for (genvar l = 0; l < 2; l++) begin : g_line
        line_st_e st_q [DEPTH];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) st_q[i] <= ST_I;
            end else if (wr_line_en[l]) begin
                st_q[wr_idx] <= wr_st[l];
            end
        end

        assign rd_st[l] = st_q[rd_idx];
    end
endmodule

// File: rtl/sect_dir_ctrl.sv
module sect_dir_ctrl
    import sect_dir_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6,
    parameter int OFFS_W = 5,
    parameter int TAG_W  = ADDR_W - IDX_W - OFFS_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_i,
    input  logic [1:0]        cpu_op_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic              fill_shared_i,
    output logic              cpu_ready_o,
    input  logic              snp_req_i,
    input  logic [ADDR_W-1:0] snp_addr_i,
    input  logic              snp_inv_i,
    output logic              snp_ready_o,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic [TAG_W-1:0]  rd_tag,
    input  line_st_e          rd_st [2],
    output logic              wr_tag_en,
    output logic [TAG_W-1:0]  wr_tag,
    output logic [1:0]        wr_line_en,
    output line_st_e          wr_st [2],
    output logic              rsp_valid_o,
    output logic              rsp_sect_hit_o,
    output logic              rsp_line_hit_o,
    output logic [1:0]        rsp_state_o,
    output logic              bus_wr_req_o,
    output logic              fill_done_o,
    output logic              snp_done_o,
    output logic              snp_hit_o,
    output logic              snp_hitm_o,
    output logic              wb_valid_o,
    output logic [ADDR_W-1:0] wb_addr_o
);
    localparam int LINE_BIT = OFFS_W;
    localparam int IDX_LO   = OFFS_W + 1;

    ctrl_st_e          state_q, state_d;
    logic [ADDR_W-1:0] fill_addr_q;
    logic              fill_shr_q;

    logic              idle, snp_take, cpu_take;
    logic [ADDR_W-1:0] cur_addr;
    logic              cur_line, present, line_hit;
    logic [TAG_W-1:0]  cur_tag;
    line_st_e          sel_st, fill_st;
    cpu_op_e           op;

    assign op          = cpu_op_e'(cpu_op_i);
    assign idle        = (state_q == S_IDLE);
    assign snp_ready_o = idle;
    assign cpu_ready_o = idle && !snp_req_i;
    assign snp_take    = idle && snp_req_i;
    assign cpu_take    = idle && cpu_req_i && !snp_req_i;

    always_comb begin
        if (!idle)          cur_addr = fill_addr_q;
        else if (snp_req_i) cur_addr = snp_addr_i;
        else                cur_addr = cpu_addr_i;
    end

    assign rd_idx   = cur_addr[IDX_LO +: IDX_W];
    assign cur_line = cur_addr[LINE_BIT];
    assign cur_tag  = cur_addr[ADDR_W-1 -: TAG_W];
    assign sel_st   = cur_line ? rd_st[1] : rd_st[0];
    assign present  = (rd_tag == cur_tag) && (rd_st[0] != ST_I || rd_st[1] != ST_I);
    assign line_hit = present && (sel_st != ST_I);
    assign fill_st  = (idle ? fill_shared_i : fill_shr_q) ? ST_S : ST_E;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= S_IDLE;
            fill_addr_q <= '0;
            fill_shr_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (cpu_take && op == OP_FILL) begin
                fill_addr_q <= cpu_addr_i;
                fill_shr_q  <= fill_shared_i;
            end
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (cpu_take && op == OP_FILL && !present) state_d = S_WB0;
            S_WB0:   state_d = S_WB1;
            S_WB1:   state_d = S_ALLOC;
            S_ALLOC: state_d = S_IDLE;
        endcase
    end

    // Store write commands
    always_comb begin
        wr_tag_en  = 1'b0;
        wr_tag     = cur_tag;
        wr_line_en = 2'b00;
        wr_st[0]   = ST_I;
        wr_st[1]   = ST_I;
        unique case (state_q)
            S_IDLE: begin
                if (snp_take && line_hit) begin
                    wr_line_en[cur_line] = 1'b1;
                    wr_st[cur_line]      = snp_inv_i ? ST_I : ST_S;
                end else if (cpu_take && op == OP_WR && line_hit && sel_st == ST_E) begin
                    wr_line_en[cur_line] = 1'b1;
                    wr_st[cur_line]      = ST_M;
                end else if (cpu_take && op == OP_FILL && present) begin
                    wr_line_en[cur_line] = 1'b1;
                    wr_st[cur_line]      = fill_st;
                end
            end
            S_ALLOC: begin
                wr_tag_en       = 1'b1;
                wr_line_en      = 2'b11;
                wr_st[cur_line] = fill_st;
            end
            default: ;
        endcase
    end

    // Writeback report while walking the old sector
    always_comb begin
        wb_valid_o = 1'b0;
        unique case (state_q)
            S_WB0:   wb_valid_o = (rd_st[0] == ST_M);
            S_WB1:   wb_valid_o = (rd_st[1] == ST_M);
            default: ;
        endcase
        wb_addr_o = {rd_tag, rd_idx, (state_q == S_WB1), {OFFS_W{1'b0}}};
    end

    // Registered responses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid_o    <= 1'b0;
            rsp_sect_hit_o <= 1'b0;
            rsp_line_hit_o <= 1'b0;
            rsp_state_o    <= 2'd0;
            bus_wr_req_o   <= 1'b0;
            fill_done_o    <= 1'b0;
            snp_done_o     <= 1'b0;
            snp_hit_o      <= 1'b0;
            snp_hitm_o     <= 1'b0;
        end else begin
            rsp_valid_o    <= cpu_take && op != OP_FILL;
            rsp_sect_hit_o <= cpu_take && op != OP_FILL && present;
            rsp_line_hit_o <= cpu_take && op != OP_FILL && line_hit;
            rsp_state_o    <= (cpu_take && op != OP_FILL && line_hit) ? sel_st : ST_I;
            bus_wr_req_o   <= cpu_take && op == OP_WR && line_hit && sel_st == ST_S;
            fill_done_o    <= (cpu_take && op == OP_FILL && present) || state_q == S_ALLOC;
            snp_done_o     <= snp_take;
            snp_hit_o      <= snp_take && line_hit;
            snp_hitm_o     <= snp_take && line_hit && sel_st == ST_M;
        end
    end
endmodule

// File: rtl/sect_dir.sv
module sect_dir
    import sect_dir_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6,
    parameter int OFFS_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_i,
    input  logic [1:0]        cpu_op_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic              fill_shared_i,
    output logic              cpu_ready_o,
    input  logic              snp_req_i,
    input  logic [ADDR_W-1:0] snp_addr_i,
    input  logic              snp_inv_i,
    output logic              snp_ready_o,
    output logic              rsp_valid_o,
    output logic              rsp_sect_hit_o,
    output logic              rsp_line_hit_o,
    output logic [1:0]        rsp_state_o,
    output logic              bus_wr_req_o,
    output logic              fill_done_o,
    output logic              snp_done_o,
    output logic              snp_hit_o,
    output logic              snp_hitm_o,
    output logic              wb_valid_o,
    output logic [ADDR_W-1:0] wb_addr_o
);
    localparam int TAG_W = ADDR_W - IDX_W - OFFS_W - 1;

    logic [IDX_W-1:0] rd_idx;
    logic [TAG_W-1:0] rd_tag, wr_tag;
    line_st_e         rd_st [2];
    line_st_e         wr_st [2];
    logic             wr_tag_en;
    logic [1:0]       wr_line_en;

    sect_dir_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(rd_idx), .rd_tag(rd_tag), .rd_st(rd_st),
        .wr_idx(rd_idx), .wr_tag_en(wr_tag_en), .wr_tag(wr_tag),
        .wr_line_en(wr_line_en), .wr_st(wr_st)
    );

    sect_dir_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFFS_W(OFFS_W), .TAG_W(TAG_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_i(cpu_req_i), .cpu_op_i(cpu_op_i), .cpu_addr_i(cpu_addr_i),
        .fill_shared_i(fill_shared_i), .cpu_ready_o(cpu_ready_o),
        .snp_req_i(snp_req_i), .snp_addr_i(snp_addr_i), .snp_inv_i(snp_inv_i),
        .snp_ready_o(snp_ready_o),
        .rd_idx(rd_idx), .rd_tag(rd_tag), .rd_st(rd_st),
        .wr_tag_en(wr_tag_en), .wr_tag(wr_tag), .wr_line_en(wr_line_en), .wr_st(wr_st),
        .rsp_valid_o(rsp_valid_o), .rsp_sect_hit_o(rsp_sect_hit_o),
        .rsp_line_hit_o(rsp_line_hit_o), .rsp_state_o(rsp_state_o),
        .bus_wr_req_o(bus_wr_req_o), .fill_done_o(fill_done_o),
        .snp_done_o(snp_done_o), .snp_hit_o(snp_hit_o), .snp_hitm_o(snp_hitm_o),
        .wb_valid_o(wb_valid_o), .wb_addr_o(wb_addr_o)
    );
endmodule

// File: rtl/sect_dir_chk.sv
module sect_dir_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       snp_req_i,
    input logic       cpu_ready_o,
    input logic       snp_ready_o,
    input logic       rsp_valid_o,
    input logic       rsp_sect_hit_o,
    input logic       rsp_line_hit_o,
    input logic [1:0] rsp_state_o,
    input logic       bus_wr_req_o,
    input logic       snp_done_o,
    input logic       snp_hit_o,
    input logic       snp_hitm_o,
    input logic       wb_valid_o
);
    assert_line_needs_sector_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_line_hit_o |-> rsp_valid_o && rsp_sect_hit_o && rsp_state_o != 2'd0);

    assert_miss_reports_invalid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && !rsp_line_hit_o) |-> rsp_state_o == 2'd0);

    assert_buswr_only_shared_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr_req_o |-> rsp_line_hit_o && rsp_state_o == 2'd1);

    assert_hitm_is_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        snp_hitm_o |-> snp_hit_o && snp_done_o);

    assert_snoop_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        snp_req_i |-> !cpu_ready_o);

    assert_one_response_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid_o && snp_done_o));

    assert_wb_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid_o |-> !snp_ready_o && !cpu_ready_o);
endmodule

bind sect_dir sect_dir_chk u_chk (
    .clk(clk), .rst_n(rst_n), .snp_req_i(snp_req_i),
    .cpu_ready_o(cpu_ready_o), .snp_ready_o(snp_ready_o),
    .rsp_valid_o(rsp_valid_o), .rsp_sect_hit_o(rsp_sect_hit_o),
    .rsp_line_hit_o(rsp_line_hit_o), .rsp_state_o(rsp_state_o),
    .bus_wr_req_o(bus_wr_req_o), .snp_done_o(snp_done_o),
    .snp_hit_o(snp_hit_o), .snp_hitm_o(snp_hitm_o), .wb_valid_o(wb_valid_o)
);

// File: tb/sect_dir_tb.sv
module sect_dir_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req_i = 1'b0;
    logic [1:0]  cpu_op_i = 2'd0;
    logic [31:0] cpu_addr_i = '0;
    logic        fill_shared_i = 1'b0;
    logic        snp_req_i = 1'b0;
    logic [31:0] snp_addr_i = '0;
    logic        snp_inv_i = 1'b0;
    logic        cpu_ready_o, snp_ready_o, rsp_valid_o, rsp_sect_hit_o, rsp_line_hit_o;
    logic [1:0]  rsp_state_o;
    logic        bus_wr_req_o, fill_done_o, snp_done_o, snp_hit_o, snp_hitm_o, wb_valid_o;
    logic [31:0] wb_addr_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // Reference model
    logic [19:0] mtag [64];
    logic [1:0]  mst [64][2];

    always #10 clk = ~clk;

    sect_dir u_dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit mpres(input logic [5:0] idx, input logic [19:0] tg);
        return mtag[idx] == tg && (mst[idx][0] != 2'd0 || mst[idx][1] != 2'd0);
    endfunction

    function automatic logic [31:0] mk(input logic [19:0] tg, input logic [5:0] idx,
                                       input bit ln, input logic [4:0] off);
        return {tg, idx, ln, off};
    endfunction

    task automatic cpu_op(input logic [1:0] op, input logic [31:0] a, input bit shr);
        logic [5:0]  idx = a[11:6];
        bit          ln  = a[5];
        logic [19:0] tg  = a[31:12];
        bit          pr  = mpres(idx, tg);
        logic [1:0]  st  = mst[idx][ln];
        bit          hit = pr && st != 2'd0;
        @(negedge clk);
        cpu_req_i = 1'b1; cpu_op_i = op; cpu_addr_i = a; fill_shared_i = shr;
        #1 chk("R9 ready", cpu_ready_o, 1);
        @(negedge clk);
        cpu_req_i = 1'b0;
        if (op != 2'd2) begin
            chk("R3 valid", rsp_valid_o, 1);
            chk("R3 sect_hit", rsp_sect_hit_o, pr);
            chk("R3 line_hit", rsp_line_hit_o, hit);
            chk("R3 state", rsp_state_o, hit ? st : 2'd0);
            chk("R5 bus_wr", bus_wr_req_o, op == 2'd1 && hit && st == 2'd1);
            if (op == 2'd1 && hit && st == 2'd2) mst[idx][ln] = 2'd3;   // R4
        end else if (pr) begin
            chk("R6 fill_done", fill_done_o, 1);
            mst[idx][ln] = shr ? 2'd1 : 2'd2;
        end else begin
            chk("R7 wb0", wb_valid_o, mst[idx][0] == 2'd3);
            if (mst[idx][0] == 2'd3) chk("R7 wb0 addr", wb_addr_o, mk(mtag[idx], idx, 0, 0));
            @(negedge clk);
            chk("R7 wb1", wb_valid_o, mst[idx][1] == 2'd3);
            if (mst[idx][1] == 2'd3) chk("R7 wb1 addr", wb_addr_o, mk(mtag[idx], idx, 1, 0));
            @(negedge clk);
            chk("R7 alloc busy", cpu_ready_o, 0);
            @(negedge clk);
            chk("R7 fill_done", fill_done_o, 1);
            mtag[idx] = tg;
            mst[idx][0] = 2'd0; mst[idx][1] = 2'd0;
            mst[idx][ln] = shr ? 2'd1 : 2'd2;
        end
    endtask

    task automatic snoop(input logic [31:0] a, input bit inv);
        logic [5:0] idx = a[11:6];
        bit         ln  = a[5];
        bit         hit = mpres(idx, a[31:12]) && mst[idx][ln] != 2'd0;
        logic [1:0] st  = mst[idx][ln];
        @(negedge clk);
        snp_req_i = 1'b1; snp_addr_i = a; snp_inv_i = inv;
        @(negedge clk);
        snp_req_i = 1'b0;
        chk("R8 done", snp_done_o, 1);
        chk("R8 hit", snp_hit_o, hit);
        chk("R8 hitm", snp_hitm_o, hit && st == 2'd3);
        if (hit) mst[idx][ln] = inv ? 2'd0 : 2'd1;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    localparam logic [19:0] TA = 20'h00001;
    localparam logic [19:0] TB = 20'h00002;
    localparam logic [19:0] TC = 20'h00ABC;

    initial begin
        for (int i = 0; i < 64; i++) begin mtag[i] = '0; mst[i][0] = 0; mst[i][1] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 cpu_ready", cpu_ready_o, 1);
        chk("R1 snp_ready", snp_ready_o, 1);
        chk("R1 rsp_valid", rsp_valid_o, 0);
        chk("R1 wb_valid", wb_valid_o, 0);
        cpu_op(2'd0, mk(20'h0, 6'd0, 0, 0), 0);
        cpu_op(2'd0, mk(20'h0, 6'd63, 1, 5'h1F), 0);

        // R7 fill to empty sector, no writebacks; R4 E -> M
        cpu_op(2'd2, mk(TA, 6'd5, 0, 0), 0);
        cpu_op(2'd0, mk(TA, 6'd5, 0, 5'h13), 0);     // R2 offset ignored
        cpu_op(2'd1, mk(TA, 6'd5, 0, 0), 0);          // R4 E -> M
        cpu_op(2'd1, mk(TA, 6'd5, 0, 0), 0);          // R4 M stays
        chk("R4 model M", mst[5][0], 2'd3);
        // R3 sector hit, line miss on sibling (bit 5)
        cpu_op(2'd0, mk(TA, 6'd5, 1, 0), 0);
        // R6 direct fill of line 1 Shared, line 0 stays M
        cpu_op(2'd2, mk(TA, 6'd5, 1, 0), 1);
        cpu_op(2'd0, mk(TA, 6'd5, 0, 0), 0);
        // R5 write on Shared
        cpu_op(2'd1, mk(TA, 6'd5, 1, 0), 0);
        cpu_op(2'd0, mk(TA, 6'd5, 1, 0), 0);
        // R10 write miss on other tag, then R8 snoops
        cpu_op(2'd1, mk(TB, 6'd5, 0, 0), 0);
        snoop(mk(TA, 6'd5, 0, 0), 0);                 // M -> S with hitm
        snoop(mk(TA, 6'd5, 1, 0), 1);                 // S -> I
        snoop(mk(TB, 6'd5, 0, 0), 1);                 // miss
        cpu_op(2'd0, mk(TA, 6'd5, 0, 0), 0);
        // R7 evict with Modified line 0 reported
        cpu_op(2'd2, mk(TA, 6'd5, 0, 0), 0);
        cpu_op(2'd1, mk(TA, 6'd5, 0, 0), 0);
        cpu_op(2'd2, mk(TB, 6'd5, 1, 0), 1);
        cpu_op(2'd0, mk(TB, 6'd5, 1, 0), 0);
        cpu_op(2'd0, mk(TA, 6'd5, 0, 0), 0);

        // R9 simultaneous requests: snoop served first
        @(negedge clk);
        cpu_req_i = 1'b1; cpu_op_i = 2'd0; cpu_addr_i = mk(TB, 6'd5, 1, 0);
        snp_req_i = 1'b1; snp_addr_i = mk(TB, 6'd5, 1, 0); snp_inv_i = 1'b1;
        #1 chk("R9 cpu blocked", cpu_ready_o, 0);
        @(negedge clk);
        snp_req_i = 1'b0;
        chk("R9 snoop done", snp_done_o, 1);
        chk("R9 no cpu rsp", rsp_valid_o, 0);
        mst[5][1] = 2'd0;
        @(negedge clk);
        cpu_req_i = 1'b0;
        chk("R9 cpu later", rsp_valid_o, 1);
        chk("R9 line now invalid", rsp_line_hit_o, 0);

        // Random phase
        begin
            int unsigned seed = 32'd1234;
            void'($urandom(seed));
            for (int n = 0; n < 1500; n++) begin
                logic [19:0] tg;
                logic [5:0]  ix;
                logic [31:0] a;
                int unsigned r = $urandom % 3;
                tg = (r == 0) ? TA : (r == 1) ? TB : TC;
                r = $urandom % 3;
                ix = (r == 0) ? 6'd5 : (r == 1) ? 6'd9 : 6'd63;
                a = mk(tg, ix, 1'($urandom), 5'($urandom));
                r = $urandom % 10;
                if (r < 3)      cpu_op(2'd0, a, 0);
                else if (r < 6) cpu_op(2'd1, a, 0);
                else if (r < 8) cpu_op(2'd2, a, 1'($urandom));
                else            snoop(a, 1'($urandom));
            end
        end
        summary();
    end
endmodule